// File: doc/BRIEF.md
# Sequential Rotate-Right Execution Unit

This unit performs the rotate-right operation of a 32-bit register-based CPU datapath. It rotates one bit position at a time, so the finishing pulse lands on the exact clock count that the instruction costs. A start pulse captures the operand, the operand size (byte, word or long) and the rotate count. The count comes either from a 3-bit immediate field or from the value of a source register. Only the sized low part of the operand is rotated. The bits above it pass through unchanged.

When the operation finishes, the unit presents the 32-bit result and the negative, zero, overflow and carry condition flags, and raises `done` for one clock. A separate memory-operand mode rotates a 16-bit word by exactly one position, whatever the size and count inputs say. The unit has no extend-flag output, so it never alters the extend flag. The unit takes no new start while an operation is in flight.

Top module: `rotr_unit`

## Requirements
- R1: With `cnt_sel`=0, the immediate field `imm_cnt` gives the count: the value 0 means a count of 8, and the values 1 to 7 are taken as they are.
- R2: With `cnt_sel`=1, the count is `reg_cnt[5:0]`, which is the source value modulo 64. The rotation wraps at the operand width, so a byte rotate by 20 gives the same data as a rotate by 4.
- R3: `size_sel` encodes the operand size: 0 is byte (bits 7:0), 1 is word (bits 15:0), and 2 or 3 is long (bits 31:0). Result bits above the size equal the operand bits.
- R4: The sized part of `result` is the sized operand rotated right by the count. Bits leaving bit 0 re-enter at the sized most significant bit.
- R5: For a non-zero count, `flag_c` equals the most significant bit of the sized result. For any count, `flag_n` is that bit, `flag_z` is 1 exactly when the sized result is zero, and `flag_v` is 0.
- R6: For a count of zero (register source only), the data is unchanged and `flag_c` is 0. `flag_n` and `flag_z` follow the sized operand.
- R7: Let start be sampled high while idle at clock edge k. Then `done` rises at edge k+T, where T = 6+2n for byte and word and T = 8+2n for long, with n the effective count (0 to 63).
- R8: `busy` is high from edge k until edge k+T. `done` is high for exactly one clock. `result` and the flags change only at the edge that raises `done` and hold until the next completion.
- R9: A start while `busy` is high is ignored. It does not change the running operation's result or timing, and it produces no extra completion.
- R10: With `mem_op`=1, the unit rotates the low 16 bits right by one and ignores `size_sel` and the count inputs. It takes T = 8. For example, 0xd567 becomes 0xeab3 with N and C set.
- R11: A synchronous active-high `rst` brings the unit to idle with `busy` and `done` low, and with `result` and all flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| size_sel | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| cnt_sel | input | 1 | Count source: 0 immediate, 1 register |
| imm_cnt | input | 3 | Immediate count field (0 means 8) |
| reg_cnt | input | 32 | Source register value holding the count |
| mem_op | input | 1 | Memory form: word rotate by one |
| operand | input | 32 | Destination operand |
| result | output | 32 | Rotated result, valid from `done` |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (always 0 after an operation) |
| flag_c | output | 1 | Carry flag |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench pulses start between clock edges and counts the edges until `done` is seen high. That count must equal 6+2n or 8+2n for the sized operation, or 8 for the memory form. The result and the flags are compared only in that completion cycle, against a rotation computed arithmetically from the sampled inputs. They are compared again one clock later, when `done` must be low and the outputs must still hold. The sweeps cover every immediate field value and all 64 register counts for each size. A dedicated case pulses start mid-operation and confirms that the original completion edge and data survive and that no extra `done` appears.

// File: rtl/rotr_pkg.sv
package rotr_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;
    localparam int TICK_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LONG2 = 2'd3
    } opsize_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef struct packed {
        state_e              st;
        logic [TICK_W-1:0]   left;
        logic [CNT_W-1:0]    n;
        opsize_e             sz;
        logic [DATA_W-1:0]   work;
        logic [DATA_W-1:0]   res;
        logic                fn;
        logic                fz;
        logic                fv;
        logic                fc;
        logic                done;
    } core_s;

endpackage

// File: rtl/rotr_count.sv
module rotr_count
    import rotr_pkg::*;
#(
    parameter int SETUP_NARROW = 6,
    parameter int SETUP_WIDE   = 8,
    parameter int STEP_CLKS    = 2
) (
    input  logic [1:0]        size_in,
    input  logic              use_reg,
    input  logic [2:0]        imm,
    input  logic [CNT_W-1:0]  reg_lo,
    input  logic              mem,
    output opsize_e           eff_size,
    output logic [CNT_W-1:0]  eff_n,
    output logic [TICK_W-1:0] total
);
    logic [TICK_W-1:0] setup;

    always_comb begin
        if (mem) begin
            eff_size = SZ_WORD;
            eff_n    = CNT_W'(1);
        end else begin
            eff_size = opsize_e'(size_in);
            if (use_reg)
                eff_n = reg_lo;
            else if (imm == 3'd0)
                eff_n = CNT_W'(8);
            else
                eff_n = CNT_W'(imm);
        end
        if (eff_size == SZ_BYTE || eff_size == SZ_WORD)
            setup = TICK_W'(SETUP_NARROW);
        else
            setup = TICK_W'(SETUP_WIDE);
        total = setup + TICK_W'(STEP_CLKS) * TICK_W'(eff_n);
    end
endmodule

// File: rtl/rotr_step.sv
module rotr_step
    import rotr_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  opsize_e           sz,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        case (sz)
            SZ_BYTE: dout = {din[31:8], din[0], din[7:1]};
            SZ_WORD: dout = {din[31:16], din[0], din[15:1]};
            default: dout = {din[0], din[31:1]};
        endcase
    end
endmodule

// File: rtl/rotr_flags.sv
module rotr_flags
    import rotr_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  opsize_e           sz,
    input  logic              moved,
    output logic              f_n,
    output logic              f_z,
    output logic              f_v,
    output logic              f_c
);
    logic top_bit;
    logic all_zero;

    always_comb begin
        case (sz)
            SZ_BYTE: begin
                top_bit  = din[7];
                all_zero = (din[7:0] == 8'h00);
            end
            SZ_WORD: begin
                top_bit  = din[15];
                all_zero = (din[15:0] == 16'h0000);
            end
            default: begin
                top_bit  = din[31];
                all_zero = (din == '0);
            end
        endcase
        f_n = top_bit;
        f_z = all_zero;
        f_v = 1'b0;
        f_c = moved & top_bit;
    end
endmodule

// File: rtl/rotr_unit.sv
module rotr_unit
    import rotr_pkg::*;
#(
    parameter int SETUP_NARROW = 6,
    parameter int SETUP_WIDE   = 8,
    parameter int STEP_CLKS    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        size_sel,
    input  logic              cnt_sel,
    input  logic [2:0]        imm_cnt,
    input  logic [31:0]       reg_cnt,
    input  logic              mem_op,
    input  logic [31:0]       operand,
    output logic [31:0]       result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              busy,
    output logic              done
);
    core_s q, d;

    opsize_e           in_size;
    logic [CNT_W-1:0]  in_n;
    logic [TICK_W-1:0] in_total;
    logic [DATA_W-1:0] stepped;
    logic              nf_n, nf_z, nf_v, nf_c;
    logic [TICK_W-1:0] span;
    logic              step_now;

    rotr_count #(
        .SETUP_NARROW(SETUP_NARROW),
        .SETUP_WIDE  (SETUP_WIDE),
        .STEP_CLKS   (STEP_CLKS)
    ) u_count (
        .size_in (size_sel),
        .use_reg (cnt_sel),
        .imm     (imm_cnt),
        .reg_lo  (reg_cnt[CNT_W-1:0]),
        .mem     (mem_op),
        .eff_size(in_size),
        .eff_n   (in_n),
        .total   (in_total)
    );

    rotr_step u_step (
        .din (q.work),
        .sz  (q.sz),
        .dout(stepped)
    );

    rotr_flags u_flags (
        .din  (q.work),
        .sz   (q.sz),
        .moved(q.n != '0),
        .f_n  (nf_n),
        .f_z  (nf_z),
        .f_v  (nf_v),
        .f_c  (nf_c)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        span     = TICK_W'(STEP_CLKS) * TICK_W'(q.n);
        step_now = (q.left < span) &&
                   ((q.left % TICK_W'(STEP_CLKS)) == TICK_W'(STEP_CLKS - 1));
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_RUN;
                    d.work = operand;
                    d.sz   = in_size;
                    d.n    = in_n;
                    d.left = in_total - TICK_W'(1);
                end
            end
            default: begin
                if (q.left == '0) begin
                    d.st   = ST_IDLE;
                    d.res  = q.work;
                    d.fn   = nf_n;
                    d.fz   = nf_z;
                    d.fv   = nf_v;
                    d.fc   = nf_c;
                    d.done = 1'b1;
                end else begin
                    d.left = q.left - TICK_W'(1);
                    if (step_now)
                        d.work = stepped;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_IDLE, sz: SZ_BYTE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign result = q.res;
    assign flag_n = q.fn;
    assign flag_z = q.fz;
    assign flag_v = q.fv;
    assign flag_c = q.fc;
    assign busy   = (q.st == ST_RUN);
    assign done   = q.done;
endmodule

// File: rtl/rotr_unit_chk.sv
module rotr_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [1:0]  size_sel,
    input logic        cnt_sel,
    input logic [2:0]  imm_cnt,
    input logic [31:0] reg_cnt,
    input logic        mem_op,
    input logic [31:0] operand,
    input logic [31:0] result,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c,
    input logic        busy,
    input logic        done
);
    logic [31:0] cap_op;
    logic [1:0]  cap_sz;
    logic [5:0]  cap_n;
    logic [7:0]  cap_t;
    logic [7:0]  since;
    logic [5:0]  want_n;
    logic [1:0]  want_sz;

    always_comb begin
        want_sz = mem_op ? 2'd1 : size_sel;
        if (mem_op)        want_n = 6'd1;
        else if (cnt_sel)  want_n = reg_cnt[5:0];
        else               want_n = (imm_cnt == 3'd0) ? 6'd8 : {3'd0, imm_cnt};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_op <= '0;
            cap_sz <= '0;
            cap_n  <= '0;
            cap_t  <= '0;
            since  <= '0;
        end else if (start && !busy) begin
            cap_op <= operand;
            cap_sz <= want_sz;
            cap_n  <= want_n;
            cap_t  <= (want_sz[1] ? 8'd8 : 8'd6) + {1'b0, want_n, 1'b0};
            since  <= '0;
        end else if (busy) begin
            since  <= since + 8'd1;
        end
    end

    a_r7_cycle_cost: assert property (@(posedge clk) disable iff (rst)
        done |-> since == cap_t);
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_busy_drop: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !done |=> (!done || $past(busy)) );
    a_r5_carry_msb: assert property (@(posedge clk) disable iff (rst)
        (done && cap_n != 6'd0) |-> flag_c == flag_n);
    a_r5_v_clear: assert property (@(posedge clk) disable iff (rst)
        done |-> !flag_v);
    a_r3_upper_byte: assert property (@(posedge clk) disable iff (rst)
        (done && cap_sz == 2'd0) |-> result[31:8] == cap_op[31:8]);
    a_r3_upper_word: assert property (@(posedge clk) disable iff (rst)
        (done && cap_sz == 2'd1) |-> result[31:16] == cap_op[31:16]);
    a_r6_zero_count: assert property (@(posedge clk) disable iff (rst)
        (done && cap_n == 6'd0) |-> (result == cap_op && !flag_c));
endmodule

bind rotr_unit rotr_unit_chk u_rotr_unit_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .size_sel(size_sel),
    .cnt_sel (cnt_sel),
    .imm_cnt (imm_cnt),
    .reg_cnt (reg_cnt),
    .mem_op  (mem_op),
    .operand (operand),
    .result  (result),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_v  (flag_v),
    .flag_c  (flag_c),
    .busy    (busy),
    .done    (done)
);

// File: tb/rotr_unit_bench.sv
`timescale 1ns/1ps
module rotr_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  size_sel = '0;
    logic        cnt_sel = 1'b0;
    logic [2:0]  imm_cnt = '0;
    logic [31:0] reg_cnt = '0;
    logic        mem_op = 1'b0;
    logic [31:0] operand = '0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rotr_unit u_rotr_unit (
        .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
        .cnt_sel(cnt_sel), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt),
        .mem_op(mem_op), .operand(operand), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_rot(input logic [31:0] x,
                                            input int w, input int n);
        logic [63:0] mask, s, r;
        int k;
        k    = n % w;
        mask = (64'd1 << w) - 64'd1;
        s    = {32'd0, x} & mask;
        r    = ((s >> k) | (s << (w - k))) & mask;
        return (x & ~mask[31:0]) | r[31:0];
    endfunction

    // Runs one operation; optionally pulses start again while busy (R9).
    task automatic run_op(input logic [1:0] sz, input bit sel, input logic [2:0] imm,
                          input logic [31:0] rv, input bit mem, input logic [31:0] op,
                          input bit poke, input string tag);
        int w, n, t, cyc;
        logic [31:0] exp_r, mask;
        logic en, ez, ec;
        if (mem) begin w = 16; n = 1; end
        else begin
            w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
            n = sel ? int'(rv[5:0]) : ((imm == 3'd0) ? 8 : int'(imm));
        end
        t     = (w == 32 ? 8 : 6) + 2 * n;
        exp_r = ref_rot(op, w, n);
        mask  = (w == 32) ? 32'hffffffff : ((32'd1 << w) - 32'd1);
        en    = exp_r[w-1];
        ez    = ((exp_r & mask) == 32'd0);
        ec    = (n != 0) && en;

        @(negedge clk);
        size_sel = sz; cnt_sel = sel; imm_cnt = imm; reg_cnt = rv;
        mem_op = mem; operand = op; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        size_sel = ~sz; imm_cnt = ~imm; reg_cnt = ~rv; operand = ~op; mem_op = 1'b0;
        cyc = 0;
        check(busy == 1'b1, "R8", "busy after start", {31'd0, busy}, 32'd1);
        while (!done && cyc < 400) begin
            if (poke && cyc == 3) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        check(cyc == t, mem ? "R10" : "R7", "cycles to done", cyc, t);
        check(result == exp_r, tag, "result", result, exp_r);
        check({flag_n, flag_z, flag_v, flag_c} == {en, ez, 1'b0, ec},
              (n == 0) ? "R6" : "R5", "flags NZVC",
              {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, en, ez, 1'b0, ec});
        if (w < 32)
            check((result & ~mask) == (op & ~mask), "R3", "upper bits",
                  result & ~mask, op & ~mask);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8", "done single pulse",
              {30'd0, done, busy}, 32'd0);
        check(result == exp_r, "R8", "result held", result, exp_r);
        if (poke) begin
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (done || busy) break;
            end
            check(done == 1'b0 && busy == 1'b0, "R9", "no extra run",
                  {30'd0, done, busy}, 32'd0);
            check(result == exp_r, "R9", "result kept", result, exp_r);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hce3dd599; pats[1] = 32'h12345600;
        pats[2] = 32'h80000001; pats[3] = 32'hffffff7e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check({result, flag_n, flag_z, flag_v, flag_c, busy, done} == '0, "R11",
              "reset outputs", result | {26'd0, flag_n, flag_z, flag_v, flag_c, busy, done}, 32'd0);

        // Known vectors (R4)
        run_op(2'd0, 1'b0, 3'd1, 32'd0, 1'b0, 32'hce3dd599, 1'b0, "R4");
        run_op(2'd0, 1'b0, 3'd7, 32'd0, 1'b0, 32'hce3dd599, 1'b0, "R4");
        run_op(2'd1, 1'b0, 3'd6, 32'd0, 1'b0, 32'hce3dd599, 1'b0, "R4");
        run_op(2'd2, 1'b0, 3'd5, 32'd0, 1'b0, 32'hce3dd599, 1'b0, "R4");
        run_op(2'd2, 1'b1, 3'd0, 32'd26, 1'b0, 32'hce3dd599, 1'b0, "R2");
        run_op(2'd0, 1'b1, 3'd0, 32'd20, 1'b0, 32'hce3dd599, 1'b0, "R2");

        // R1 all immediate fields, all sizes
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 8; f++)
                for (int p = 0; p < 4; p++)
                    run_op(2'(s), 1'b0, 3'(f), 32'hffffffff, 1'b0, pats[p], 1'b0, "R1");

        // R2 / R6 all register counts, upper source bits set
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < 64; c++)
                for (int p = 0; p < 2; p++)
                    run_op(2'(s), 1'b1, 3'd5, {26'h3ffffff, 6'(c)}, 1'b0, pats[p], 1'b0,
                           (c == 0) ? "R6" : "R2");

        // R10 memory form, size and count inputs disregarded
        run_op(2'd0, 1'b1, 3'd3, 32'd9, 1'b1, 32'hffffd567, 1'b0, "R10");
        run_op(2'd2, 1'b0, 3'd0, 32'd0, 1'b1, 32'h0000d560, 1'b0, "R10");

        // R9 start while busy ignored
        run_op(2'd2, 1'b1, 3'd0, 32'd30, 1'b0, 32'hce3dd599, 1'b1, "R9");
        run_op(2'd0, 1'b0, 3'd2, 32'd0, 1'b0, 32'h000000c3, 1'b1, "R9");

        // R11 reset mid-operation
        @(negedge clk);
        size_sel = 2'd2; cnt_sel = 1'b1; reg_cnt = 32'd40; operand = 32'h5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check({busy, done, flag_n, flag_z, flag_v, flag_c} == '0 && result == '0, "R11",
              "reset mid-run", result | {26'd0, busy, done, flag_n, flag_z, flag_v, flag_c}, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule